// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block moves stereo audio between a parallel sample interface and a single serial data line. It does not generate the serial clocks. The bit clock arrives as two one-cycle strobes in the system clock domain, one for each rising and one for each falling bit-clock edge, and the word clock arrives as a level. The receive half turns the incoming line into a left and right sample pair. The transmit half turns a queued sample pair into a bit stream on the outgoing line.

Three inputs set the framing. `cfg_fmt` picks one of three word placements: leading-edge aligned, aligned one bit after the leading edge, or trailing-edge aligned. `cfg_wlen` picks the word width. `cfg_frame64` picks a 64-slot frame or a 32-slot frame. Receive samples come out sign-extended to 24 bits with a one-cycle valid pulse. Transmit samples are taken in through a valid/ready handshake and are read from their top bits.

Receive state machine states are `R_IDLE`, `R_HUNT`, `R_LEFT` and `R_RIGHT`:
- `prime` moves from `R_IDLE` to `R_HUNT` on the second rise strobe.
- `left_start` moves from `R_HUNT` to `R_LEFT`.
- `left_done` moves from `R_LEFT` to `R_RIGHT` and stores the left word.
- `pair_done` moves from `R_RIGHT` to `R_LEFT` and publishes the pair.

The transmit machine has the same shape, with states `T_IDLE`, `T_HUNT`, `T_LEFT` and `T_RIGHT` and transitions `prime`, `left_start`, `left_done` and `pair_done`. It evaluates them on fall strobes. On every entry into `T_LEFT` it loads a pending pair if one is waiting.

Top module: `serial_audio_port`

## Requirements
- R1: `cfg_fmt` encodes the word placement within each half frame.
  - 0 = MSB in the first slot after a word-clock change.
  - 1 = MSB in the second slot after the change.
  - 2 = LSB in the last slot before the next change.
  - 3 behaves as 0.
- R2: Each frame carries the left channel first. In format 1 a low word clock marks the left half. In formats 0, 2 and 3 a high word clock marks the left half.
- R3: With `cfg_frame64`=1 a half frame is 32 slots, and `cfg_wlen` 0/1/2/3 selects 16/18/20/24-bit words. With `cfg_frame64`=0 a half frame is 16 slots and the word is 16 bits whatever `cfg_wlen` says.
- R4: The receiver samples `sdata_in` and `lr_clk` on `bck_rise`. Line values in slots outside the word's placement do not affect the received sample.
- R5: Received words are sign-extended to 24 bits on `rx_left` and `rx_right`. These outputs change only with a one-cycle `rx_valid` pulse. The pulse comes after both halves of a frame are complete, on the word-clock change that ends the right half (one slot later in format 1).
- R6: `sdata_out` changes only in the cycle after `bck_fall`. It sends the top W bits of the 24-bit input MSB first and is low in all unused slots.
- R7: A pair is accepted when `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low, and further offers are ignored, until the pair is loaded at the start of the next left half.
- R8: When no pair is pending at the start of a left half, the transmitter sends the previous pair again.
- R9: Reset values are `rx_valid`=0, `sdata_out`=0 and `tx_ready`=1. After reset each side waits two strobes and then for the start of a left half. No partial frame is published or transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bck_rise | input | 1 | One-cycle strobe at each bit-clock rising edge |
| bck_fall | input | 1 | One-cycle strobe at each bit-clock falling edge |
| lr_clk | input | 1 | Word clock level |
| sdata_in | input | 1 | Serial receive data |
| sdata_out | output | 1 | Serial transmit data |
| cfg_fmt | input | 2 | Word placement select |
| cfg_wlen | input | 2 | Word width select |
| cfg_frame64 | input | 1 | 1 = 64-slot frame, 0 = 32-slot frame |
| rx_left | output | 24 | Received left sample, sign-extended |
| rx_right | output | 24 | Received right sample, sign-extended |
| rx_valid | output | 1 | Received pair strobe |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit pair holding register empty |

## Verification
The embedded assertions watch these properties on every cycle:
- `rx_valid` is a single-cycle pulse that follows a rise strobe, and the receive outputs move only with it.
- `sdata_out` moves only after a fall strobe and stays low while idle.
- `tx_ready` rises only on a fall strobe and never rises between strobes.

Bit placement for each format, word width and frame size, the word-clock polarity, sign extension, the ignored filler slots, repetition of the previous pair and the absence of a partial first frame all depend on whole frames of stimulus. The bench checks them by comparing against its own slot-by-slot model of the serial line.

// File: rtl/sap_pkg.sv
package sap_pkg;
    localparam int SMP_W  = 24;
    localparam int SLOT_W = 6;

    localparam logic [1:0] FMT_LJ  = 2'd0;
    localparam logic [1:0] FMT_I2S = 2'd1;
    localparam logic [1:0] FMT_RJ  = 2'd2;

    function automatic logic chan_is_left(logic [1:0] fmt, logic lrv);
        return (fmt == FMT_I2S) ? ~lrv : lrv;
    endfunction

    function automatic logic [SLOT_W-1:0] word_len(logic [1:0] code, logic f64);
        if (!f64) return SLOT_W'(16);
        case (code)
            2'd0:    return SLOT_W'(16);
            2'd1:    return SLOT_W'(18);
            2'd2:    return SLOT_W'(20);
            default: return SLOT_W'(24);
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] half_len(logic f64);
        return f64 ? SLOT_W'(32) : SLOT_W'(16);
    endfunction

    function automatic logic [SMP_W-1:0] sext_low(logic [SMP_W-1:0] v, logic [SLOT_W-1:0] w);
        logic [SLOT_W-1:0]        sh;
        logic signed [SMP_W-1:0]  t;
        sh = SLOT_W'(SMP_W) - w;
        t  = $signed(v << sh);
        return t >>> sh;
    endfunction
endpackage

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_rise,
    input  logic              lr_clk,
    input  logic              sdin,
    input  logic [1:0]        fmt,
    input  logic [SLOT_W-1:0] wlen,
    output logic [SMP_W-1:0]  rx_left,
    output logic [SMP_W-1:0]  rx_right,
    output logic              rx_valid
);
    typedef enum logic [1:0] {R_IDLE, R_HUNT, R_LEFT, R_RIGHT} rx_state_e;

    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    rx_state_e          state, state_n;
    logic               primed;
    logic               lr_d1, lr_d2;
    logic               eff, peff, edge_seen;
    logic [SLOT_W-1:0]  slot, slot_n;
    logic               in_win;
    logic [SMP_W-1:0]   shreg, shreg_n, word, left_buf;

    always_comb begin
        eff       = (fmt == FMT_I2S) ? lr_d1 : lr_clk;
        peff      = (fmt == FMT_I2S) ? lr_d2 : lr_d1;
        edge_seen = (eff != peff);
        slot_n    = edge_seen ? '0 : ((slot == SLOT_MAX) ? slot : slot + 1'b1);
        in_win    = (fmt == FMT_RJ) ? 1'b1 : (slot_n < wlen);
        shreg_n   = in_win ? {shreg[SMP_W-2:0], sdin} : shreg;
        word      = sext_low(shreg, wlen);
    end

    always_comb begin
        state_n = state;
        if (bck_rise) begin
            unique case (state)
                R_IDLE:  if (primed) state_n = R_HUNT;
                R_HUNT:  if (edge_seen && chan_is_left(fmt, eff)) state_n = R_LEFT;
                R_LEFT:  if (edge_seen) state_n = R_RIGHT;
                R_RIGHT: if (edge_seen) state_n = R_LEFT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed   <= 1'b0;
            lr_d1    <= 1'b0;
            lr_d2    <= 1'b0;
            slot     <= '0;
            shreg    <= '0;
            left_buf <= '0;
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (bck_rise) begin
                primed <= 1'b1;
                lr_d1  <= lr_clk;
                lr_d2  <= lr_d1;
                slot   <= slot_n;
                shreg  <= shreg_n;
                if (state == R_LEFT && edge_seen)
                    left_buf <= word;
                if (state == R_RIGHT && edge_seen) begin
                    rx_left  <= left_buf;
                    rx_right <= word;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r4_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bck_rise));
    a_r5_outputs_move_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_left) |-> rx_valid);
endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_fall,
    input  logic              lr_clk,
    input  logic [1:0]        fmt,
    input  logic [SLOT_W-1:0] wlen,
    input  logic [SLOT_W-1:0] hlen,
    input  logic [SMP_W-1:0]  tx_left,
    input  logic [SMP_W-1:0]  tx_right,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              sdout
);
    typedef enum logic [1:0] {T_IDLE, T_HUNT, T_LEFT, T_RIGHT} tx_state_e;

    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    tx_state_e          state, state_n;
    logic               primed;
    logic               lr_d1, lr_d2;
    logic               eff, peff, edge_seen, to_left, load;
    logic [SLOT_W-1:0]  slot, slot_n, lead, pos;
    logic               in_word, next_bit;
    logic [SMP_W-1:0]   hold_l, hold_r, act_l, act_r, word, shifted;
    logic               hold_full;

    assign tx_ready = ~hold_full;

    always_comb begin
        eff       = (fmt == FMT_I2S) ? lr_d1 : lr_clk;
        peff      = (fmt == FMT_I2S) ? lr_d2 : lr_d1;
        edge_seen = (eff != peff);
        slot_n    = edge_seen ? '0 : ((slot == SLOT_MAX) ? slot : slot + 1'b1);
        to_left   = edge_seen && chan_is_left(fmt, eff);
    end

    always_comb begin
        state_n = state;
        if (bck_fall) begin
            unique case (state)
                T_IDLE:  if (primed) state_n = T_HUNT;
                T_HUNT:  if (to_left) state_n = T_LEFT;
                T_LEFT:  if (edge_seen) state_n = T_RIGHT;
                T_RIGHT: if (edge_seen) state_n = T_LEFT;
            endcase
        end
    end

    always_comb begin
        load = bck_fall && to_left && hold_full &&
               (state == T_HUNT || state == T_RIGHT);
        if (chan_is_left(fmt, eff)) word = load ? hold_l : act_l;
        else                        word = load ? hold_r : act_r;
        lead = hlen - wlen;
        if (fmt == FMT_RJ) begin
            pos     = slot_n - lead;
            in_word = (slot_n >= lead) && (slot_n < hlen);
        end else begin
            pos     = slot_n;
            in_word = (slot_n < wlen);
        end
        shifted  = word << pos;
        next_bit = in_word && (state_n == T_LEFT || state_n == T_RIGHT) &&
                   shifted[SMP_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= T_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            lr_d1     <= 1'b0;
            lr_d2     <= 1'b0;
            slot      <= '0;
            hold_l    <= '0;
            hold_r    <= '0;
            hold_full <= 1'b0;
            act_l     <= '0;
            act_r     <= '0;
            sdout     <= 1'b0;
        end else begin
            if (load) begin
                act_l     <= hold_l;
                act_r     <= hold_r;
                hold_full <= 1'b0;
            end else if (tx_valid && !hold_full) begin
                hold_l    <= tx_left;
                hold_r    <= tx_right;
                hold_full <= 1'b1;
            end
            if (bck_fall) begin
                primed <= 1'b1;
                lr_d1  <= lr_clk;
                lr_d2  <= lr_d1;
                slot   <= slot_n;
                sdout  <= next_bit;
            end
        end
    end

    a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> $past(bck_fall));
    a_r7_ready_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(bck_fall));
    a_r7_full_kept_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !bck_fall) |=> !tx_ready);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_IDLE) |-> !sdout);
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import sap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bck_rise,
    input  logic             bck_fall,
    input  logic             lr_clk,
    input  logic             sdata_in,
    output logic             sdata_out,
    input  logic [1:0]       cfg_fmt,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_frame64,
    output logic [SMP_W-1:0] rx_left,
    output logic [SMP_W-1:0] rx_right,
    output logic             rx_valid,
    input  logic [SMP_W-1:0] tx_left,
    input  logic [SMP_W-1:0] tx_right,
    input  logic             tx_valid,
    output logic             tx_ready
);
    logic [SLOT_W-1:0] wlen_eff, hlen_eff;

    assign wlen_eff = word_len(cfg_wlen, cfg_frame64);
    assign hlen_eff = half_len(cfg_frame64);

    sap_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_rise (bck_rise),
        .lr_clk   (lr_clk),
        .sdin     (sdata_in),
        .fmt      (cfg_fmt),
        .wlen     (wlen_eff),
        .rx_left  (rx_left),
        .rx_right (rx_right),
        .rx_valid (rx_valid)
    );

    sap_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_fall (bck_fall),
        .lr_clk   (lr_clk),
        .fmt      (cfg_fmt),
        .wlen     (wlen_eff),
        .hlen     (hlen_eff),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .sdout    (sdata_out)
    );
endmodule

// File: tb/serial_audio_port_tb.sv
module serial_audio_port_tb;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [1:0]  wl;
        logic        f64;
        logic [23:0] rl;
        logic [23:0] rr;
        logic [23:0] tl;
        logic [23:0] tr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 2'd3, 1'b1, 24'h812345, 24'h3C5A96, 24'hA5C3F1, 24'h1E2D4B},
        '{2'd1, 2'd3, 1'b1, 24'h7F00FF, 24'h800001, 24'hC0FFEE, 24'h13579B},
        '{2'd2, 2'd3, 1'b1, 24'hF0F0F0, 24'h0F0F0F, 24'h2468AC, 24'hFDB975},
        '{2'd0, 2'd2, 1'b1, 24'h9ABCDE, 24'h456789, 24'hE1E2E3, 24'h6A5B4C},
        '{2'd1, 2'd1, 1'b1, 24'hB6DB6D, 24'h49249F, 24'h8C3A5F, 24'h77EE11},
        '{2'd2, 2'd0, 1'b1, 24'hCAFE12, 24'h7E57AB, 24'hDEAD99, 24'h00FF77},
        '{2'd0, 2'd0, 1'b0, 24'h9876FF, 24'h1234AA, 24'hF00D55, 24'h0BAD66},
        '{2'd1, 2'd0, 1'b0, 24'h8001AB, 24'h7FFE01, 24'hA001CD, 24'h5FFD02},
        '{2'd2, 2'd0, 1'b0, 24'hC3C3C3, 24'h3C3C3C, 24'h55AA55, 24'hAA55AA},
        '{2'd2, 2'd2, 1'b1, 24'hE00001, 24'h1FFFF0, 24'h999999, 24'h666666},
        '{2'd1, 2'd3, 1'b0, 24'hFEDCBA, 24'h012345, 24'h89ABCD, 24'h7654FF},
        '{2'd3, 2'd3, 1'b1, 24'h808080, 24'h7F7F7F, 24'hB0B1B2, 24'h4C4D4E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck_rise = 1'b0, bck_fall = 1'b0, lr_clk = 1'b0, sdata_in = 1'b0;
    logic        sdata_out;
    logic [1:0]  cfg_fmt = 2'd0, cfg_wlen = 2'd3;
    logic        cfg_frame64 = 1'b1;
    logic [23:0] rx_left, rx_right, tx_left = '0, tx_right = '0;
    logic        rx_valid, tx_valid = 1'b0, tx_ready;

    int          n_checks = 0, n_errors = 0;
    int          got_n = 0;
    logic [23:0] got_l = '0, got_r = '0;
    logic [23:0] rx_prev, tx_prev;

    always #(CLK_P/2) clk = ~clk;

    serial_audio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bck_rise(bck_rise), .bck_fall(bck_fall),
        .lr_clk(lr_clk), .sdata_in(sdata_in), .sdata_out(sdata_out),
        .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_frame64(cfg_frame64),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
        .tx_left(tx_left), .tx_right(tx_right), .tx_valid(tx_valid),
        .tx_ready(tx_ready)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got_l = rx_left;
            got_r = rx_right;
            got_n = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wbits(logic [1:0] wl, logic f64);
        if (!f64) return 16;
        case (wl)
            2'd0: return 16;
            2'd1: return 18;
            2'd2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] exp_rx(logic [23:0] v, int w);
        logic signed [23:0] s;
        s = v;
        s = s >>> (24 - w);
        return s;
    endfunction

    // {in_word, bit} for slot k of a half, per R1
    function automatic logic [1:0] bitval(int fmt, int w, int h, logic [23:0] cur,
                                          logic [23:0] prev, int k);
        int p;
        logic [23:0] wd;
        wd = cur;
        if (fmt == 2) p = k - (h - w);
        else if (fmt == 1) begin
            if (k == 0) begin wd = prev; p = h - 1; end
            else p = k - 1;
        end else p = k;
        if (p >= 0 && p < w) return {1'b1, wd[23-p]};
        return 2'b00;
    endfunction

    task automatic one_slot(input logic lrv, input logic din, output logic seen);
        @(negedge clk); bck_fall = 1'b1; lr_clk = lrv; sdata_in = din;
        @(negedge clk); bck_fall = 1'b0;
        @(negedge clk); seen = sdata_out; bck_rise = 1'b1;
        @(negedge clk); bck_rise = 1'b0;
    endtask

    task automatic run_frame(input int fmt, input int w, input int h,
                             input logic [23:0] rl, input logic [23:0] rr,
                             input logic [23:0] tl, input logic [23:0] tr,
                             input bit chk, output int errs);
        logic [1:0]  v, e;
        logic        seen, lrv;
        logic [23:0] rcur, tcur;
        errs = 0;
        for (int ch = 0; ch < 2; ch++) begin
            rcur = (ch == 1) ? rr : rl;
            tcur = (ch == 1) ? tr : tl;
            lrv  = (fmt == 1) ? (ch == 1) : (ch == 0);   // R2 polarity
            for (int k = 0; k < h; k++) begin
                v = bitval(fmt, w, h, rcur, rx_prev, k);
                one_slot(lrv, v[1] ? v[0] : 1'b1, seen);   // R4 noise in unused slots
                e = bitval(fmt, w, h, tcur, tx_prev, k);
                if (chk && seen !== (e[1] & e[0])) errs++;
            end
            rx_prev = rcur;
            tx_prev = tcur;
        end
    endtask

    task automatic do_reset(input logic idle_lr);
        @(negedge clk); rst_n = 1'b0; lr_clk = idle_lr; bck_rise = 0; bck_fall = 0;
        tx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk); tx_left = l; tx_right = r; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int errs, w, h, fmt;
        vec_t vc;

        // R9 reset values
        do_reset(1'b0);
        check(rx_valid == 1'b0, "R9", "rx_valid after reset", 32'(rx_valid), 0);
        check(sdata_out == 1'b0, "R9", "sdata_out after reset", 32'(sdata_out), 0);
        check(tx_ready == 1'b1, "R9", "tx_ready after reset", 32'(tx_ready), 1);

        for (int i = 0; i < NV; i++) begin
            vc  = VECS[i];
            fmt = int'(vc.fmt);
            w   = wbits(vc.wl, vc.f64);              // R3
            h   = vc.f64 ? 32 : 16;
            cfg_fmt = vc.fmt; cfg_wlen = vc.wl; cfg_frame64 = vc.f64;
            do_reset(fmt == 1 ? 1'b1 : 1'b0);
            got_n = 0; rx_prev = '0; tx_prev = '0;

            push(vc.tl, vc.tr);
            check(tx_ready == 1'b0, "R7", $sformatf("v%0d ready after accept", i), 32'(tx_ready), 0);

            run_frame(fmt, w, h, ~vc.rl, ~vc.rr, vc.tl, vc.tr, 1'b0, errs);
            tx_prev = '0;
            check(tx_ready == 1'b0, "R7", $sformatf("v%0d ready held before left start", i), 32'(tx_ready), 0);
            check(got_n == 0, "R9", $sformatf("v%0d no partial frame", i), 32'(got_n), 0);

            run_frame(fmt, w, h, vc.rl, vc.rr, vc.tl, vc.tr, 1'b1, errs);
            check(errs == 0, "R1 R6", $sformatf("v%0d tx bit mismatches", i), 32'(errs), 0);
            check(tx_ready == 1'b1, "R7", $sformatf("v%0d ready after load", i), 32'(tx_ready), 1);

            run_frame(fmt, w, h, 24'h5A5A5A, 24'hA5A5A5, vc.tl, vc.tr, 1'b1, errs);
            check(errs == 0, "R8", $sformatf("v%0d repeated pair mismatches", i), 32'(errs), 0);

            check(got_n == 1, "R5", $sformatf("v%0d rx_valid pulses", i), 32'(got_n), 1);
            check(got_l == exp_rx(vc.rl, w), "R2 R4 R5", $sformatf("v%0d rx_left", i),
                  32'(got_l), 32'(exp_rx(vc.rl, w)));
            check(got_r == exp_rx(vc.rr, w), "R3 R4 R5", $sformatf("v%0d rx_right", i),
                  32'(got_r), 32'(exp_rx(vc.rr, w)));
        end

        // R7: an offer while full is ignored
        cfg_fmt = 2'd0; cfg_wlen = 2'd3; cfg_frame64 = 1'b1;
        do_reset(1'b0);
        rx_prev = '0; tx_prev = '0;
        push(24'hABCDEF, 24'h123456);
        @(negedge clk); tx_left = 24'h111111; tx_right = 24'h222222; tx_valid = 1'b1;
        repeat (3) @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R7", "ready low while offer pending", 32'(tx_ready), 0);
        run_frame(0, 24, 32, 24'h0, 24'h0, 24'h0, 24'h0, 1'b0, errs);
        tx_prev = '0;
        run_frame(0, 24, 32, 24'h0, 24'h0, 24'hABCDEF, 24'h123456, 1'b1, errs);
        check(errs == 0, "R7", "first pair kept, later offer dropped", 32'(errs), 0);
        run_frame(0, 24, 32, 24'h0, 24'h0, 24'hABCDEF, 24'h123456, 1'b1, errs);
        check(errs == 0, "R8", "pair repeated without new offer", 32'(errs), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule